// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects up to 32 level-held interrupt request lines and presents them to a processor as two interrupt outputs. Software configures it over a small 32-bit register bus. It holds an enable mask, which is changed through a write-one-to-set port and a write-one-to-clear port. It also holds a per-source routing word that picks which of the two outputs each enabled source drives.

The source lines are sampled into a raw status register each cycle. Two read-only masked status words show what is pending on each output. The top bit of the enable mask is not an ordinary source enable. It acts as a global gate, and neither output can rise while it is low.

The sources are level-held, so there is nothing to acknowledge. A request stays visible for as long as its line is high and it is enabled. Software silences a source by clearing its enable bit or by removing the cause at the source.

Top module: `irq_router`

## Requirements
- R1: After reset the enable mask, the routing word and both interrupt outputs are all zero.
- R2: A write to offset 0x34 sets every mask bit whose data bit is 1 and leaves every other mask bit unchanged. A read of 0x34 returns the current mask.
- R3: A write to offset 0x38 clears every mask bit whose data bit is 1 and leaves every other mask bit unchanged. Writing 0xFFFFFFFF there clears the whole mask, including bit 31. A read of 0x38 returns zero.
- R4: A read of offset 0x30 returns the source levels as they were sampled at the previous clock edge.
- R5: A read of offset 0x00 returns raw AND mask AND NOT routing, and a read of offset 0x04 returns raw AND mask AND routing. Both are limited to bits 0..30, so bit 31 always reads 0.
- R6: Output irq0_o is high when mask bit 31 is set and the status word at 0x00 is nonzero; irq1_o does the same for the word at 0x04. Each output is registered. It follows a source change two edges later and a mask or routing write one edge after the write edge.
- R7: While mask bit 31 is 0, both outputs stay low whatever the sources, mask and routing hold.
- R8: A read of any offset other than 0x00, 0x04, 0x20, 0x30, 0x34 and 0x38 returns zero. A write to any offset other than 0x20, 0x34 and 0x38 changes neither the mask nor the routing word.
- R9: Offset 0x20 holds the routing word and reads it back. A routing bit of 0 sends that source to output 0 and a bit of 1 sends it to output 1, so an all-zero routing word sends every source to output 0.
- R10: There is no acknowledge. An output stays high for every cycle its enabled source stays high, and it drops two edges after the source falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-held interrupt request lines |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq0_o | output | 1 | Interrupt output 0 |
| irq1_o | output | 1 | Interrupt output 1 |

## Verification
Register reads are combinational, so the bench samples them a fraction of a nanosecond after setting the offset at a falling edge. A register write takes effect at the next rising edge, and the bench reads it back at the falling edge after that. A source change reaches the raw and masked status words one edge later and the outputs two edges later. A write reaches the outputs one edge after the write edge. Dedicated timing checks sample the cycle before and the cycle after each of these points. The sweep checks wait two full cycles after the last stimulus before comparing.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq0_o,
  output logic            irq1_o
);
  localparam int GB = NSRC - 1;
  localparam logic [AW-1:0] A_ST0  = AW'(8'h00);
  localparam logic [AW-1:0] A_ST1  = AW'(8'h04);
  localparam logic [AW-1:0] A_TYPE = AW'(8'h20);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h30);
  localparam logic [AW-1:0] A_SET  = AW'(8'h34);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h38);
  localparam logic [NSRC-1:0] SRC_BITS = {1'b0, {(NSRC-1){1'b1}}};

  logic [NSRC-1:0] raw_q, mask_q, type_q;
  logic [NSRC-1:0] st0, st1;
  logic            irq0_q, irq1_q;

  wire wr_set  = bus_wr && (bus_addr == A_SET);
  wire wr_clr  = bus_wr && (bus_addr == A_CLR);
  wire wr_type = bus_wr && (bus_addr == A_TYPE);

  assign st0 = raw_q & mask_q & ~type_q & SRC_BITS;
  assign st1 = raw_q & mask_q &  type_q & SRC_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      type_q <= '0;
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      raw_q <= src_i;
      if (wr_set)
        mask_q <= mask_q | bus_wdata;
      else if (wr_clr)
        mask_q <= mask_q & ~bus_wdata;
      if (wr_type)
        type_q <= bus_wdata;
      irq0_q <= mask_q[GB] && (st0 != '0);
      irq1_q <= mask_q[GB] && (st1 != '0);
    end
  end

  always_comb begin
    case (bus_addr)
      A_ST0:   bus_rdata = st0;
      A_ST1:   bus_rdata = st1;
      A_TYPE:  bus_rdata = type_q;
      A_RAW:   bus_rdata = raw_q;
      A_SET:   bus_rdata = mask_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(bus_wdata)) == '0));

  // R7
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0_o || irq1_o) |-> $past(mask_q[GB]));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_set && !wr_clr && !wr_type) |=> ($stable(mask_q) && $stable(type_q)));

  // R10
  level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_q) == '0) |-> (!irq0_o && !irq1_o));
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq0_o, irq1_o;
  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] e_st(input logic [31:0] s, m, t, input bit one);
    return s & m & (one ? t : ~t) & 32'h7fff_ffff;
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h34, v); chk("R1 mask", v, 32'h0);
    rd(8'h20, v); chk("R1 type", v, 32'h0);
    chk("R1 irq0", {31'd0, irq0_o}, 32'd0);
    chk("R1 irq1", {31'd0, irq1_o}, 32'd0);

    wr(8'h34, 32'h0000_00f0);
    wr(8'h34, 32'h0f00_0000);
    rd(8'h34, v); chk("R2 set", v, 32'h0f00_00f0);
    wr(8'h34, 32'h0);
    rd(8'h34, v); chk("R2 set zero", v, 32'h0f00_00f0);
    wr(8'h38, 32'h0000_0030);
    rd(8'h34, v); chk("R3 clr", v, 32'h0f00_00c0);
    wr(8'h38, 32'h0);
    rd(8'h34, v); chk("R3 clr zero", v, 32'h0f00_00c0);
    rd(8'h38, v); chk("R3 clr reads 0", v, 32'h0);

    wr(8'h10, 32'hffff_ffff);
    wr(8'h00, 32'hffff_ffff);
    wr(8'h30, 32'hffff_ffff);
    rd(8'h34, v); chk("R8 mask kept", v, 32'h0f00_00c0);
    rd(8'h20, v); chk("R8 type kept", v, 32'h0);
    rd(8'h10, v); chk("R8 read 0x10", v, 32'h0);
    rd(8'h3c, v); chk("R8 read 0x3c", v, 32'h0);
    rd(8'hff, v); chk("R8 read 0xff", v, 32'h0);

    wr(8'h34, 32'h8000_0000);
    wr(8'h38, 32'hffff_ffff);
    rd(8'h34, v); chk("R3 clear all", v, 32'h0);

    @(negedge clk); src_i = 32'ha5a5_5a5a;
    @(negedge clk);
    rd(8'h30, v); chk("R4 raw", v, 32'ha5a5_5a5a);
    @(negedge clk); src_i = 32'h0;
    @(negedge clk);
    rd(8'h30, v); chk("R4 raw zero", v, 32'h0);

    wr(8'h34, 32'h8000_0002);
    @(negedge clk); src_i = 32'h2;
    @(negedge clk);
    chk("R6 irq0 not yet", {31'd0, irq0_o}, 32'd0);
    rd(8'h00, v); chk("R5 st0 early", v, 32'h2);
    @(negedge clk);
    chk("R6 irq0 due", {31'd0, irq0_o}, 32'd1);
    chk("R6 irq1 low", {31'd0, irq1_o}, 32'd0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk("R10 hold", {31'd0, irq0_o}, 32'd1);
    end
    src_i = 32'h0;
    @(negedge clk);
    chk("R10 still high", {31'd0, irq0_o}, 32'd1);
    @(negedge clk);
    chk("R10 dropped", {31'd0, irq0_o}, 32'd0);

    src_i = 32'h2;
    settle();
    chk("R6 re-raise", {31'd0, irq0_o}, 32'd1);
    wr(8'h38, 32'h8000_0000);
    chk("R6 write +0", {31'd0, irq0_o}, 32'd1);
    @(negedge clk);
    chk("R7 write +1", {31'd0, irq0_o}, 32'd0);
    wr(8'h20, 32'h2);
    wr(8'h34, 32'h8000_0000);
    chk("R6 route +0", {31'd0, irq1_o}, 32'd0);
    @(negedge clk);
    chk("R9 route +1", {31'd0, irq1_o}, 32'd1);
    chk("R9 irq0 off", {31'd0, irq0_o}, 32'd0);

    wr(8'h38, 32'hffff_ffff);
    wr(8'h34, 32'h7fff_ffff);
    wr(8'h20, 32'h5555_5555);
    src_i = 32'hffff_ffff;
    settle();
    chk("R7 irq0 gated", {31'd0, irq0_o}, 32'd0);
    chk("R7 irq1 gated", {31'd0, irq1_o}, 32'd0);
    rd(8'h04, v); chk("R5 st1 ungated", v, 32'h5555_5555);

    wr(8'h20, 32'h0);
    wr(8'h34, 32'h8000_0000);
    src_i = 32'h7fff_ffff;
    settle();
    rd(8'h20, v); chk("R9 type zero", v, 32'h0);
    rd(8'h00, v); chk("R9 all to st0", v, 32'h7fff_ffff);
    rd(8'h04, v); chk("R9 st1 empty", v, 32'h0);
    chk("R9 irq0", {31'd0, irq0_o}, 32'd1);
    chk("R9 irq1", {31'd0, irq1_o}, 32'd0);

    src_i = 32'h8000_0000;
    settle();
    rd(8'h00, v); chk("R5 bit31 st0", v, 32'h0);
    chk("R5 bit31 irq0", {31'd0, irq0_o}, 32'd0);

    for (int i = 0; i < 31; i++) begin
      for (int t = 0; t < 2; t++) begin
        logic [31:0] b;
        b = 32'd1 << i;
        wr(8'h20, t ? b : 32'h0);
        wr(8'h38, 32'hffff_ffff);
        wr(8'h34, b | 32'h8000_0000);
        src_i = b;
        settle();
        rd(8'h00, v); chk("R5 sweep st0", v, t ? 32'h0 : b);
        rd(8'h04, v); chk("R5 sweep st1", v, t ? b : 32'h0);
        chk("R9 sweep irq0", {31'd0, irq0_o}, t ? 32'd0 : 32'd1);
        chk("R9 sweep irq1", {31'd0, irq1_o}, t ? 32'd1 : 32'd0);
      end
    end

    for (int k = 0; k < 48; k++) begin
      logic [31:0] s, m, t, e0, e1;
      s = 32'(k + 1) * 32'h9e37_79b9;
      m = ~(32'(k) * 32'h85eb_ca6b);
      t = (32'(k) * 32'hc2b2_ae35) ^ 32'h5bd1_e995;
      wr(8'h20, t);
      wr(8'h38, 32'hffff_ffff);
      wr(8'h34, m);
      src_i = s;
      settle();
      e0 = e_st(s, m, t, 1'b0);
      e1 = e_st(s, m, t, 1'b1);
      rd(8'h30, v); chk("R4 pat raw", v, s);
      rd(8'h34, v); chk("R2 pat mask", v, m);
      rd(8'h20, v); chk("R9 pat type", v, t);
      rd(8'h00, v); chk("R5 pat st0", v, e0);
      rd(8'h04, v); chk("R5 pat st1", v, e1);
      chk("R6 pat irq0", {31'd0, irq0_o}, {31'd0, m[31] && (e0 != 0)});
      chk("R6 pat irq1", {31'd0, irq1_o}, {31'd0, m[31] && (e1 != 0)});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule